// File: doc/BRIEF.md
# Control-Word Driven 8-bit ALU

A purely combinational arithmetic and logic unit for a small accumulator-style datapath. It takes two operands, A and B, and a five-bit control word whose bits are not an opcode but raw steering strobes: one conditionally inverts B, one feeds the adder carry-in, one forces the adder's B input to zero, and two pick which of four sources reaches the result. A single ripple-carry adder is shared by add, subtract, increment, pass, add-plus-one and subtract-minus-one.

The conditioned B operand is built in two steps. First each bit is XORed with the invert strobe. Then each bit is ANDed with the inverse of the zero strobe, so zeroing wins over inversion. The bitwise AND source and the pass-B source always see the raw B operand. The adder's carry-out and the zero flag are reported on every cycle, whatever source is selected. The surrounding sequencer decides whether to capture them.

Top module: `salu_top`

## Requirements
- R1: Control word bits are ctrl[4]=zero-B, ctrl[3]=invert-B, ctrl[2]=carry-in, ctrl[1:0]=output select. With select 00 the result is (A + B' + ctrl[2]) mod 256, where B' is the conditioned operand.
- R2: Select 01 gives A AND B using the unmodified B, whatever ctrl[4:2] hold.
- R3: Select 10 passes A unchanged, and select 11 passes the unmodified B unchanged.
- R4: ctrl[3]=1 XORs every B bit with 1 before the adder, so ctrl=01100 gives A-B in two's complement. Its carry-out is 1 exactly when A >= B unsigned (1-1 gives carry 1).
- R5: ctrl[4]=1 forces the adder's B input to zero, so ctrl=10100 gives A+1 and ctrl=10000 gives A. Incrementing FF gives result 00 with carry 1.
- R6: ctrl=00100 gives A+B+1, and ctrl=01000 gives A-B-1 (A + ~B).
- R7: The zero flag is 1 exactly when all eight result bits are 0, for every select value.
- R8: carryOut is the adder's carry of A + B' + ctrl[2] even when the select picks a non-adder source.
- R9: Zeroing applies after inversion, so with ctrl[4]=1 the value of ctrl[3] has no effect on the adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| ctrlWord | input | 5 | Raw control strobes {zeroB, invertB, carryIn, sel[1:0]} |
| result | output | 8 | Selected result |
| carryOut | output | 1 | Raw adder carry-out |
| zeroFlag | output | 1 | High when result is all zeros |

## Verification
The adder path is tried with carry-free sums, sums that wrap past 255 and sums that land exactly on zero. These separate a correct carry chain from one that drops or misroutes the top carry. Subtraction is driven with A above, equal to and below B, which shows whether the carry-in and the inversion both reach the adder. The non-adder selects are paired with operands whose adder carry differs from the selected value, and with strobes that would change the result if they leaked into the AND or pass paths. A model-driven sweep over all 32 control words then compares every output against the requirement equations on several operand pairs.

// File: rtl/salu_pkg.sv
package salu_pkg;
  localparam int CTRL_W = 5;

  typedef enum logic [1:0] {
    SEL_SUM  = 2'b00,
    SEL_AND  = 2'b01,
    SEL_A    = 2'b10,
    SEL_B    = 2'b11
  } outSel_e;

  typedef struct packed {
    logic    zeroB;
    logic    invertB;
    logic    carryIn;
    outSel_e outSel;
  } strobes_t;
endpackage

// File: rtl/salu_decode.sv
module salu_decode
  import salu_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrlWord,
  output strobes_t          strobes
);
  always_comb begin
    strobes.zeroB   = ctrlWord[4];
    strobes.invertB = ctrlWord[3];
    strobes.carryIn = ctrlWord[2];
    strobes.outSel  = outSel_e'(ctrlWord[1:0]);
  end
endmodule

// File: rtl/salu_datapath.sv
module salu_datapath
  import salu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  strobes_t         strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             zeroFlag
);
  logic [WIDTH-1:0] invB;
  logic [WIDTH-1:0] condB;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH:0]   carryChain;
  logic [WIDTH-1:0] andBits;

  assign carryChain[0] = strobes.carryIn;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      assign invB[i]    = opB[i] ^ strobes.invertB;
      assign condB[i]   = invB[i] & ~strobes.zeroB;
      assign sumBits[i] = opA[i] ^ condB[i] ^ carryChain[i];
      assign carryChain[i+1] = (opA[i] & condB[i]) |
                               (carryChain[i] & (opA[i] ^ condB[i]));
      assign andBits[i] = opA[i] & opB[i];
    end
  endgenerate

  always_comb begin
    unique case (strobes.outSel)
      SEL_SUM: result = sumBits;
      SEL_AND: result = andBits;
      SEL_A:   result = opA;
      SEL_B:   result = opB;
      default: result = sumBits;
    endcase
  end

  assign carryOut = carryChain[WIDTH];
  assign zeroFlag = ~|result;

  // Cross-checks between the conditioning stage, adder chain and selector
  always_comb begin
    if (strobes.outSel == SEL_A)
      p_pass_a_r3: assert (result == opA);
    if (strobes.outSel == SEL_AND)
      p_and_raw_b_r2: assert (result == (opA & opB));
    if (strobes.zeroB && strobes.outSel == SEL_SUM)
      p_zero_b_r5: assert (result == opA + {{(WIDTH-1){1'b0}}, strobes.carryIn});
    if (strobes.invertB && strobes.carryIn && !strobes.zeroB)
      p_sub_carry_r4: assert (carryOut == (opA >= opB));
    p_zero_flag_r7: assert (zeroFlag == (result == '0));
  end
endmodule

// File: rtl/salu_top.sv
module salu_top
  import salu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [CTRL_W-1:0] ctrlWord,
  output logic [WIDTH-1:0]  result,
  output logic              carryOut,
  output logic              zeroFlag
);
  strobes_t strobes;

  salu_decode u_decode (
    .ctrlWord (ctrlWord),
    .strobes  (strobes)
  );

  salu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .result   (result),
    .carryOut (carryOut),
    .zeroFlag (zeroFlag)
  );
endmodule

// File: tb/salu_top_tb_top.sv
module salu_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] opA, opB;
  logic [4:0] ctrlWord;
  logic [7:0] result;
  logic       carryOut, zeroFlag;
  int         checkCount = 0;
  int         failCount  = 0;

  always #10 clk = ~clk;

  salu_top dut_i (
    .opA(opA), .opB(opB), .ctrlWord(ctrlWord),
    .result(result), .carryOut(carryOut), .zeroFlag(zeroFlag)
  );

  // {ctrl[4:0], a[7:0], b[7:0], result[7:0], carry, zero}
  localparam int NVEC = 18;
  localparam logic [30:0] VEC [NVEC] = '{
    {5'b00000, 8'h7B, 8'h2D, 8'hA8, 1'b0, 1'b0}, // R1
    {5'b00000, 8'hFA, 8'h0A, 8'h04, 1'b1, 1'b0}, // R1 wrap
    {5'b00000, 8'h80, 8'h80, 8'h00, 1'b1, 1'b1}, // R1 to zero
    {5'b01100, 8'h7B, 8'h2D, 8'h4E, 1'b1, 1'b0}, // R4 A>B
    {5'b01100, 8'h01, 8'h01, 8'h00, 1'b1, 1'b1}, // R4 equal
    {5'b01100, 8'h2D, 8'h7B, 8'hB2, 1'b0, 1'b0}, // R4 A<B
    {5'b10100, 8'h7B, 8'h55, 8'h7C, 1'b0, 1'b0}, // R5 inc
    {5'b10100, 8'hFF, 8'h12, 8'h00, 1'b1, 1'b1}, // R5 inc wrap
    {5'b10000, 8'h5A, 8'h33, 8'h5A, 1'b0, 1'b0}, // R5 pass through adder
    {5'b00100, 8'h7B, 8'h2D, 8'hA9, 1'b0, 1'b0}, // R6 A+B+1
    {5'b01000, 8'h7B, 8'h2D, 8'h4D, 1'b1, 1'b0}, // R6 A-B-1
    {5'b00001, 8'hAA, 8'hF0, 8'hA0, 1'b1, 1'b0}, // R2 / R8
    {5'b01101, 8'h0F, 8'hF0, 8'h00, 1'b0, 1'b1}, // R2 raw B
    {5'b00010, 8'h3C, 8'hC3, 8'h3C, 1'b0, 1'b0}, // R3 pass A
    {5'b11111, 8'h3C, 8'hC3, 8'hC3, 1'b0, 1'b0}, // R3 pass raw B / R9
    {5'b11000, 8'hFF, 8'hAB, 8'hFF, 1'b0, 1'b0}, // R9 zero wins
    {5'b00011, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1}, // R3 / R7
    {5'b01111, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b1}  // R8 carry on non-adder
  };

  function automatic string tagOf(int idx);
    case (idx)
      0, 1, 2:  tagOf = "R1";
      3, 4, 5:  tagOf = "R4";
      6, 7, 8:  tagOf = "R5";
      9, 10:    tagOf = "R6";
      11, 12:   tagOf = "R2";
      13, 16:   tagOf = "R3";
      14, 15:   tagOf = "R9";
      default:  tagOf = "R8";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    checkCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h (ctrl=%b a=%0h b=%0h)",
               tag, what, got, exp, ctrlWord, opA, opB);
    end
  endtask

  task automatic apply(input logic [4:0] c, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    ctrlWord = c; opA = a; opB = b;
    @(posedge clk);
    #1;
  endtask

  // Requirement equations, independent of the RTL structure
  task automatic model(input logic [4:0] c, input logic [7:0] a, input logic [7:0] b,
                       output logic [7:0] r, output logic cy, output logic z);
    logic [7:0] bb;
    logic [8:0] s;
    bb = c[3] ? ~b : b;
    if (c[4]) bb = 8'h00;
    s = {1'b0, a} + {1'b0, bb} + {8'h00, c[2]};
    case (c[1:0])
      2'b00: r = s[7:0];
      2'b01: r = a & b;
      2'b10: r = a;
      default: r = b;
    endcase
    cy = s[8];
    z = (r == 8'h00);
  endtask

  initial begin
    #(20 * 20000);
    failCount++;
    checkCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    logic [7:0] mr;
    logic mc, mz;
    ctrlWord = 5'b0; opA = 8'h00; opB = 8'h00;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    #1;
    // Quiet state: all-zero inputs, add select (R7 zero, R1 sum)
    check("R7", "idle zero", {7'b0, zeroFlag}, 8'h01);
    check("R1", "idle result", result, 8'h00);
    check("R8", "idle carry", {7'b0, carryOut}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][30:26], VEC[i][25:18], VEC[i][17:10]);
      check(tagOf(i), "result", result, VEC[i][9:2]);
      check(tagOf(i), "carry", {7'b0, carryOut}, {7'b0, VEC[i][1]});
      check(tagOf(i), "zero", {7'b0, zeroFlag}, {7'b0, VEC[i][0]});
    end

    // Sweep of every control word against the requirement equations (R1..R9)
    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] a, b;
        case (k)
          0: begin a = 8'h00; b = 8'hFF; end
          1: begin a = 8'hFF; b = 8'hFF; end
          2: begin a = 8'h96; b = 8'h69; end
          default: begin a = 8'h41; b = 8'hC7; end
        endcase
        apply(c[4:0], a, b);
        model(c[4:0], a, b, mr, mc, mz);
        check("R1_R9_sweep", "result", result, mr);
        check("R8", "carry", {7'b0, carryOut}, {7'b0, mc});
        check("R7", "zero", {7'b0, zeroFlag}, {7'b0, mz});
      end
    end

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule